// File: doc/BRIEF.md
# Page Migration Reference Monitor

This block supports moving pages between nodes of a distributed shared-memory machine. It keeps two reference counters for each page. One counts accesses from the home node and the other counts accesses from remote nodes. Every access that is served updates the counter for the requester's side. The block then checks whether the remote count leads the home count by more than a programmable margin. When it does, the block raises a one-cycle interrupt that carries the page index. A local processor then copies the page elsewhere.

Once the copy is done, software poisons the source page. Any access to a poisoned page gets an error response instead of a normal completion. The accessor can then refresh its stale translation later, so translations are shot down lazily rather than all at once. An unpoison command returns the page to service with fresh counters. A clear command restarts counting and re-arms the interrupt without touching the poison flag. The copy engine and all translation logic sit outside this block.

Top module: `pmig_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `resp_valid` and `irq_valid` are 0. After reset every page is unpoisoned, both of its counters are zero, its interrupt is armed, and the threshold holds `THR_RESET` (default 4).
- R2: Every access (`acc_valid`=1) is answered by `resp_valid`=1 exactly one cycle later. `resp_valid` is 0 in any cycle that follows a cycle with no access. `resp_err` is 0 for an access to an unpoisoned page.
- R3: An access to an unpoisoned page adds one to that page's remote counter when `acc_remote`=1, or to its home counter when `acc_remote`=0.
- R4: After a counter update, if the remote count minus the home count is greater than the threshold and the page is armed, then `irq_valid` is 1 for one cycle. This is the cycle after the access, and `irq_page` carries that page index. The page is then disarmed.
- R5: Writing `thr_wdata` with `thr_we`=1 sets the threshold. An access in the same cycle as the write is still compared against the previous threshold. Accesses in later cycles use the new value.
- R6: Both counters saturate at 2^CNT_W-1 rather than wrapping to zero.
- R7: A disarmed page raises no further interrupt, whatever its counts. Command `cmd_op`=2'b11 (clear) sets both counters of `cmd_page` to zero and re-arms it, and leaves its poison flag unchanged.
- R8: Command `cmd_op`=2'b01 poisons `cmd_page`. From the next cycle on, an access to that page gets `resp_valid`=1 with `resp_err`=1. Such an access changes no counter and raises no interrupt.
- R9: Command `cmd_op`=2'b10 unpoisons `cmd_page`, sets both of its counters to zero and re-arms it. `cmd_op`=2'b00 is no command.
- R10: If a command and an access name the same page in the same cycle, the access's response uses the poison state from before the command. The access makes no counter update and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_page | input | PAGE_W | Page index of the access |
| acc_remote | input | 1 | 1 = requester is a remote node, 0 = home node |
| cmd_op | input | 2 | 00 none, 01 poison, 10 unpoison, 11 clear counters |
| cmd_page | input | PAGE_W | Page index the command applies to |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | CNT_W | New threshold value |
| resp_valid | output | 1 | Registered response for the previous cycle's access |
| resp_err | output | 1 | The response is a bus error (page poisoned) |
| irq_valid | output | 1 | One-cycle migration interrupt |
| irq_page | output | PAGE_W | Page that triggered the interrupt |

## Verification
A corrupted counter or a lost armed bit shows up only as an interrupt that comes at the wrong access, or never comes. The bench therefore tracks every page's counts and compares `irq_valid`/`irq_page` on the cycle after each access, so a single-step error appears on the next triggering access. A poison bit that is wrong turns up as a wrong `resp_err` on the very next access to that page. Saturation and the same-cycle ordering between a command and an access get directed sequences, because random traffic reaches them rarely.

// File: rtl/pmig_pkg.sv
package pmig_pkg;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'b00,
    CMD_POISON   = 2'b01,
    CMD_UNPOISON = 2'b10,
    CMD_CLEAR    = 2'b11
  } pmig_cmd_e;

endpackage

// File: rtl/pmig_poison_map.sv
module pmig_poison_map #(
  parameter int NUM_PAGES = 16,
  parameter int PAGE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [PAGE_W-1:0] rd_page,
  output logic              rd_poisoned
);

  logic [NUM_PAGES-1:0] poison_vec;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    always_ff @(posedge clk) begin
      if (rst) begin
        poison_vec[g] <= 1'b0;
      end else if (cmd_page == PAGE_W'(g)) begin
        if (set_en)      poison_vec[g] <= 1'b1;
        else if (clr_en) poison_vec[g] <= 1'b0;
      end
    end
  end

  assign rd_poisoned = poison_vec[rd_page];

  AST_POISON_SET: assert property (@(posedge clk) disable iff (rst)
    set_en |=> poison_vec[$past(cmd_page)]); // R8

  AST_POISON_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !poison_vec[$past(cmd_page)]); // R9

endmodule

// File: rtl/pmig_count_bank.sv
module pmig_count_bank #(
  parameter int NUM_PAGES = 16,
  parameter int PAGE_W    = 4,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] rd_page,
  output logic [CNT_W-1:0]  rd_loc,
  output logic [CNT_W-1:0]  rd_rem,
  output logic              rd_armed,
  input  logic              upd_en,
  input  logic [PAGE_W-1:0] upd_page,
  input  logic [CNT_W-1:0]  upd_loc,
  input  logic [CNT_W-1:0]  upd_rem,
  input  logic              upd_armed,
  input  logic              clr_en,
  input  logic [PAGE_W-1:0] clr_page
);

  logic [CNT_W-1:0] loc_mem [NUM_PAGES];
  logic [CNT_W-1:0] rem_mem [NUM_PAGES];
  logic             arm_mem [NUM_PAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PAGES; i++) begin
        loc_mem[i] <= '0;
        rem_mem[i] <= '0;
        arm_mem[i] <= 1'b1;
      end
    end else begin
      if (upd_en) begin
        loc_mem[upd_page] <= upd_loc;
        rem_mem[upd_page] <= upd_rem;
        arm_mem[upd_page] <= upd_armed;
      end
      if (clr_en) begin
        loc_mem[clr_page] <= '0;
        rem_mem[clr_page] <= '0;
        arm_mem[clr_page] <= 1'b1;
      end
    end
  end

  assign rd_loc   = loc_mem[rd_page];
  assign rd_rem   = rem_mem[rd_page];
  assign rd_armed = arm_mem[rd_page];

  AST_CLEAR_REARMS: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> arm_mem[$past(clr_page)]); // R7

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> (loc_mem[$past(clr_page)] == '0) && (rem_mem[$past(clr_page)] == '0)); // R9

endmodule

// File: rtl/pmig_trigger.sv
module pmig_trigger #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] loc_q,
  input  logic [CNT_W-1:0] rem_q,
  input  logic             armed_q,
  input  logic             is_remote,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] loc_n,
  output logic [CNT_W-1:0] rem_n,
  output logic             fire
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] lead;

  always_comb begin
    loc_n = loc_q;
    rem_n = rem_q;
    if (is_remote) begin
      if (rem_q != CNT_MAX) rem_n = rem_q + 1'b1;
    end else begin
      if (loc_q != CNT_MAX) loc_n = loc_q + 1'b1;
    end
    lead = rem_n - loc_n;
    fire = armed_q && (rem_n > loc_n) && (lead > thr);
  end

  always_comb begin
    AST_NO_WRAP: assert (loc_n >= loc_q && rem_n >= rem_q); // R6
  end

endmodule

// File: rtl/pmig_monitor.sv
module pmig_monitor
  import pmig_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int CNT_W     = 8,
  parameter int THR_RESET = 4,
  parameter int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic              acc_remote,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              thr_we,
  input  logic [CNT_W-1:0]  thr_wdata,
  output logic              resp_valid,
  output logic              resp_err,
  output logic              irq_valid,
  output logic [PAGE_W-1:0] irq_page
);

  localparam logic [CNT_W-1:0] THR_INIT = CNT_W'(THR_RESET);

  pmig_cmd_e        cmd;
  logic [CNT_W-1:0] thr_q;
  logic             poisoned;
  logic             cmd_hit;
  logic             upd_en;
  logic             clr_en;
  logic [CNT_W-1:0] loc_q, rem_q, loc_n, rem_n;
  logic             armed_q;
  logic             fire;
  logic             fire_eff;

  assign cmd      = pmig_cmd_e'(cmd_op);
  assign cmd_hit  = (cmd != CMD_NONE) && (cmd_page == acc_page);
  assign upd_en   = acc_valid && !poisoned && !cmd_hit;
  assign fire_eff = upd_en && fire;
  assign clr_en   = (cmd == CMD_CLEAR) || (cmd == CMD_UNPOISON);

  pmig_poison_map #(
    .NUM_PAGES (NUM_PAGES),
    .PAGE_W    (PAGE_W)
  ) u_poison (
    .clk         (clk),
    .rst         (rst),
    .set_en      (cmd == CMD_POISON),
    .clr_en      (cmd == CMD_UNPOISON),
    .cmd_page    (cmd_page),
    .rd_page     (acc_page),
    .rd_poisoned (poisoned)
  );

  pmig_count_bank #(
    .NUM_PAGES (NUM_PAGES),
    .PAGE_W    (PAGE_W),
    .CNT_W     (CNT_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .rd_page   (acc_page),
    .rd_loc    (loc_q),
    .rd_rem    (rem_q),
    .rd_armed  (armed_q),
    .upd_en    (upd_en),
    .upd_page  (acc_page),
    .upd_loc   (loc_n),
    .upd_rem   (rem_n),
    .upd_armed (armed_q && !fire),
    .clr_en    (clr_en),
    .clr_page  (cmd_page)
  );

  pmig_trigger #(
    .CNT_W (CNT_W)
  ) u_trig (
    .loc_q     (loc_q),
    .rem_q     (rem_q),
    .armed_q   (armed_q),
    .is_remote (acc_remote),
    .thr       (thr_q),
    .loc_n     (loc_n),
    .rem_n     (rem_n),
    .fire      (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q      <= THR_INIT;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      irq_valid  <= 1'b0;
      irq_page   <= '0;
    end else begin
      if (thr_we) thr_q <= thr_wdata;
      resp_valid <= acc_valid;
      resp_err   <= acc_valid && poisoned;
      irq_valid  <= fire_eff;
      if (fire_eff) irq_page <= acc_page;
    end
  end

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> resp_valid); // R2

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !resp_valid); // R2

  AST_IRQ_WITH_RESP: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> resp_valid && !resp_err); // R4

  AST_ERR_WITH_RESP: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> resp_valid); // R8

  AST_IRQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_valid && $stable(irq_page) && !acc_valid |=> !irq_valid); // R4

endmodule

// File: tb/pmig_monitor_bench.sv
`timescale 1ns/1ps
module pmig_monitor_bench;

  localparam int NP   = 16;
  localparam int CW   = 8;
  localparam int PW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          acc_valid;
  logic [PW-1:0] acc_page;
  logic          acc_remote;
  logic [1:0]    cmd_op;
  logic [PW-1:0] cmd_page;
  logic          thr_we;
  logic [CW-1:0] thr_wdata;
  logic          resp_valid, resp_err, irq_valid;
  logic [PW-1:0] irq_page;

  always #2.5 clk = ~clk;

  pmig_monitor #(.NUM_PAGES(NP), .CNT_W(CW), .THR_RESET(4)) u_pmig_monitor (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_page(acc_page),
    .acc_remote(acc_remote), .cmd_op(cmd_op), .cmd_page(cmd_page),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .resp_valid(resp_valid),
    .resp_err(resp_err), .irq_valid(irq_valid), .irq_page(irq_page)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int m_loc [NP];
  int m_rem [NP];
  bit m_arm [NP];
  bit m_poi [NP];
  int m_thr;

  function automatic int sat_inc(input int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  function automatic bit lead_exceeds(input int r, input int l, input int t);
    return (r > l) && ((r - l) > t);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      m_loc[i] = 0; m_rem[i] = 0; m_arm[i] = 1'b1; m_poi[i] = 1'b0;
    end
    m_thr = 4;
  endtask

  task automatic step(input bit av, input int pg, input bit rm, input logic [1:0] op,
                      input int cp, input bit tw, input int td, input string tag);
    bit e_err, e_irq;
    int nl, nr;
    @(negedge clk);
    acc_valid = av; acc_page = PW'(pg); acc_remote = rm;
    cmd_op = op; cmd_page = PW'(cp); thr_we = tw; thr_wdata = CW'(td);
    e_err = av && m_poi[pg];
    e_irq = 1'b0;
    if (av && !m_poi[pg] && !(op != 2'b00 && cp == pg)) begin
      nl = rm ? m_loc[pg] : sat_inc(m_loc[pg]);
      nr = rm ? sat_inc(m_rem[pg]) : m_rem[pg];
      e_irq = m_arm[pg] && lead_exceeds(nr, nl, m_thr);
      m_loc[pg] = nl; m_rem[pg] = nr;
      if (e_irq) m_arm[pg] = 1'b0;
    end
    if (tw) m_thr = td;
    case (op)
      2'b01: m_poi[cp] = 1'b1;
      2'b10: begin m_poi[cp] = 1'b0; m_loc[cp] = 0; m_rem[cp] = 0; m_arm[cp] = 1'b1; end
      2'b11: begin m_loc[cp] = 0; m_rem[cp] = 0; m_arm[cp] = 1'b1; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    chk(tag, "resp_valid", int'(resp_valid), int'(av));
    chk(tag, "resp_err", int'(resp_err), int'(e_err));
    chk(tag, "irq_valid", int'(irq_valid), int'(e_irq));
    if (e_irq) chk(tag, "irq_page", int'(irq_page), pg);
  endtask

  task automatic acc(input int pg, input bit rm, input string tag);
    step(1'b1, pg, rm, 2'b00, 0, 1'b0, 0, tag);
  endtask

  task automatic cmd(input logic [1:0] op, input int cp, input string tag);
    step(1'b0, 0, 1'b0, op, cp, 1'b0, 0, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1dc0_0ffe));
    rst = 1'b1; acc_valid = 0; acc_page = 0; acc_remote = 0;
    cmd_op = 0; cmd_page = 0; thr_we = 0; thr_wdata = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "resp_valid in reset", int'(resp_valid), 0);
    chk("R1", "irq_valid in reset", int'(irq_valid), 0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 0, 1'b0, 2'b00, 0, 1'b0, 0, "R1");

    // R1/R4: default threshold 4, fifth remote access fires
    for (int i = 0; i < 5; i++) acc(3, 1'b1, "R4");
    // R7: disarmed, no further interrupt
    for (int i = 0; i < 4; i++) acc(3, 1'b1, "R7");
    cmd(2'b11, 3, "R7");
    for (int i = 0; i < 5; i++) acc(3, 1'b1, "R7");

    // R3: home accesses raise the margin
    acc(5, 1'b0, "R3"); acc(5, 1'b0, "R3");
    for (int i = 0; i < 7; i++) acc(5, 1'b1, "R3");

    // R5: threshold write, same-cycle access uses old value
    step(1'b1, 6, 1'b1, 2'b00, 0, 1'b1, 0, "R5");
    acc(6, 1'b1, "R5");
    step(1'b1, 6, 1'b0, 2'b00, 0, 1'b1, 4, "R5");

    // R8: poisoned page gives errors, no counting, no interrupt
    cmd(2'b01, 7, "R8");
    for (int i = 0; i < 8; i++) acc(7, 1'b1, "R8");
    // R9: unpoison returns the page with zero counts
    cmd(2'b10, 7, "R9");
    for (int i = 0; i < 5; i++) acc(7, 1'b1, "R9");
    // R7: clear keeps the poison flag
    cmd(2'b01, 8, "R7");
    cmd(2'b11, 8, "R7");
    acc(8, 1'b1, "R7");
    cmd(2'b10, 8, "R9");

    // R10: command and access on the same page in one cycle
    for (int i = 0; i < 4; i++) acc(10, 1'b1, "R10");
    step(1'b1, 10, 1'b1, 2'b01, 10, 1'b0, 0, "R10");
    acc(10, 1'b1, "R10");
    step(1'b1, 10, 1'b1, 2'b10, 10, 1'b0, 0, "R10");
    acc(10, 1'b1, "R10");
    step(1'b1, 11, 1'b1, 2'b01, 12, 1'b0, 0, "R10");

    // R6: home counter saturates instead of wrapping
    for (int i = 0; i < CMAX + 5; i++) acc(9, 1'b0, "R6");
    for (int i = 0; i < 20; i++) acc(9, 1'b1, "R6");
    for (int i = 0; i < CMAX + 10; i++) acc(13, 1'b1, "R6");
    cmd(2'b11, 13, "R6");

    // R3: random traffic on a few pages
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [1:0] op;
      r  = $urandom_range(0, 99);
      op = (r < 3) ? 2'b01 : (r < 6) ? 2'b10 : (r < 10) ? 2'b11 : 2'b00;
      step($urandom_range(0, 9) != 0, $urandom_range(0, 3), $urandom_range(0, 2) != 0,
           op, $urandom_range(0, 3), $urandom_range(0, 49) == 0,
           $urandom_range(0, 6), "R3");
    end
    step(1'b0, 0, 1'b0, 2'b00, 0, 1'b0, 0, "R2");
    finish_run();
  end

endmodule